// File: doc/BRIEF.md
# Iterative Multiply/Divide Step ALU

This block is the 32-bit arithmetic unit of a processor where multiplication and division are never done in one go. Each call performs exactly one primitive step. Software repeats a multiply step sixteen times, or a divide step thirty-two times, and keeps the running state in ordinary registers. The block also does add, subtract and bitwise logic. For a word-addressed memory it can place a byte into a word or pull a byte out of one. A single carry-lookahead adder serves every arithmetic operation, so only one function is active in a cycle.

The caller presents an opcode, two operands, the auxiliary state (an upper word, a lower word and one saved bit) and a byte index. One clock edge later the result word and the updated auxiliary state appear on registered outputs. For a multiply, software loads the multiplier into the lower word, clears the upper word and the saved bit, and passes the multiplicand as operand A on every step. For a divide, it loads the dividend into the lower word, clears the upper word, and passes the divisor as operand A. After the final step, software adds the divisor back once if the remainder came out negative.

Top module: `step_alu`

## Requirements
- R1: Opcode 0 gives the result A+B modulo 2^32, and opcode 1 gives A-B modulo 2^32.
- R2: Opcode 2 gives A AND B, opcode 3 gives A OR B, and opcode 4 gives A XOR B.
- R3: Opcode 5 is one radix-4 Booth step. The window {lo_i[1], lo_i[0], bit_i} selects the addend: 000 and 111 give 0, 001 and 010 give +A, 011 gives +2A, 100 gives -2A, and 101 and 110 give -A. The addend is added to the sign-extended upper word. The pair {sum, lo_i} is then shifted right arithmetically by two bits. hi_o and lo_o are the two halves of the shifted pair, bit_o equals lo_i[1], and res_o equals hi_o.
- R4: Sixteen chained Booth steps, started from hi=0, bit=0 and lo=Y with A=X, leave {hi_o, lo_o} equal to the signed 64-bit product X*Y.
- R5: Opcode 6 is one nonrestoring divide step. The pair {hi_i, lo_i} is shifted left by one bit. A is added to the upper half when hi_i is negative and subtracted from it otherwise. hi_o is that new remainder, lo_o is {lo_i[30:0], NOT hi_o[31]}, and res_o equals hi_o.
- R6: Thirty-two chained divide steps, started from hi=0 and lo=N with divisor D in 1..2^30-1, leave lo_o equal to N/D (unsigned). hi_o, plus D when it is negative, equals N mod D.
- R7: Opcode 7 replaces byte sel_i of A (bits 8*sel_i+7 down to 8*sel_i) with B[7:0] and keeps the other bytes of A.
- R8: Opcode 8 returns byte sel_i of A in res_o[7:0], with zeros in res_o[31:8].
- R9: Every opcode other than 5 and 6 copies hi_i, lo_i and bit_i to hi_o, lo_o and bit_o. Opcodes 9 to 15 give res_o = 0.
- R10: All outputs are registered, so an operation becomes visible after the next rising clock edge. A synchronous active-high reset forces all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A (multiplicand, divisor, or word for byte ops) |
| b_i | input | 32 | Operand B (byte value in bits 7:0 for insert) |
| hi_i | input | 32 | Upper auxiliary word: partial product or remainder |
| lo_i | input | 32 | Lower auxiliary word: multiplier or quotient |
| bit_i | input | 1 | Saved Booth bit |
| sel_i | input | 2 | Byte index for insert and extract |
| res_o | output | 32 | Result word |
| hi_o | output | 32 | Updated upper auxiliary word |
| lo_o | output | 32 | Updated lower auxiliary word |
| bit_o | output | 1 | Updated saved Booth bit |

## Verification
The assertions check, on every cycle, the behaviour that can be seen from a single operation:
- the clearing effect of reset;
- that auxiliary state passes through unchanged for non-step opcodes;
- the zero result of spare opcodes;
- the upper zeros of an extract and the lane written by an insert;
- the two-bit right shift and saved-bit hand-off of a Booth step;
- the quotient bit and left shift of a divide step.

The arithmetic values (the recoded addend, the subtract-or-add choice, carry propagation through the lookahead adder) can only be shown by the bench. It compares single steps against independent models. Only chained runs can show that sixteen Booth steps form a correct signed product and that thirty-two divide steps form a correct quotient and remainder, including extreme operands and the largest allowed divisor.

// File: rtl/step_alu_pkg.sv
package step_alu_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;
    localparam int GUARD  = 2;
    localparam int ADD_W  = DATA_W + GUARD;
    localparam int CLA_GS = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADD_W-1:0]  wide_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_MSTEP = 4'd5,
        OP_DSTEP = 4'd6,
        OP_BINS  = 4'd7,
        OP_BEXT  = 4'd8
    } alu_op_e;

    // Recoded multiplier digit: magnitude 0, 1 or 2 with a sign.
    typedef struct packed {
        logic zero;
        logic dbl;
        logic neg;
    } booth_sel_t;

    typedef struct packed {
        word_t res;
        word_t hi;
        word_t lo;
        logic  bt;
    } alu_out_t;

    function automatic booth_sel_t booth_recode(input logic [2:0] win);
        booth_sel_t s;
        s = '{zero: 1'b0, dbl: 1'b0, neg: 1'b0};
        unique case (win)
            3'b000, 3'b111: s.zero = 1'b1;
            3'b001, 3'b010: s.neg  = 1'b0;
            3'b011:         s.dbl  = 1'b1;
            3'b100:         begin s.dbl = 1'b1; s.neg = 1'b1; end
            default:        s.neg  = 1'b1;
        endcase
        return s;
    endfunction

    function automatic wide_t sext_word(input word_t v);
        return {{GUARD{v[DATA_W-1]}}, v};
    endfunction

    function automatic logic is_step_op(input logic [OP_W-1:0] op);
        return (op == OP_MSTEP) || (op == OP_DSTEP);
    endfunction

endpackage

// File: rtl/step_alu_cla.sv
module step_alu_cla #(
    parameter int W  = 34,
    parameter int GS = 2
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] s_o
);
    localparam int NG = W / GS;

    logic [W-1:0]  gen, prop, cin_bit;
    logic [NG-1:0] grp_cin;
    logic [NG-2:0] grp_g, grp_p;

    assign gen  = x_i & y_i;
    assign prop = x_i ^ y_i;

    // Lookahead across groups: each group carry from the group terms.
    always_comb begin
        grp_cin[0] = c_i;
        for (int k = 1; k < NG; k++) begin
            grp_cin[k] = grp_g[k-1] | (grp_p[k-1] & grp_cin[k-1]);
        end
    end

    for (genvar k = 0; k < NG; k++) begin : g_grp
        logic [GS-1:0] lc;

        if (k < NG - 1) begin : g_terms
            logic gl, pl;
            always_comb begin
                gl = 1'b0;
                pl = 1'b1;
                for (int j = 0; j < GS; j++) begin
                    gl = gen[k*GS+j] | (prop[k*GS+j] & gl);
                    pl = pl & prop[k*GS+j];
                end
            end
            assign grp_g[k] = gl;
            assign grp_p[k] = pl;
        end

        always_comb begin
            lc[0] = grp_cin[k];
            for (int j = 1; j < GS; j++) begin
                lc[j] = gen[k*GS+j-1] | (prop[k*GS+j-1] & lc[j-1]);
            end
        end
        assign cin_bit[k*GS +: GS] = lc;
    end

    assign s_o = prop ^ cin_bit;

endmodule

// File: rtl/step_alu_bytes.sv
module step_alu_bytes #(
    parameter int W  = 32,
    parameter int BW = 8
) (
    input  logic [W-1:0]              word_i,
    input  logic [BW-1:0]             val_i,
    input  logic [$clog2(W/BW)-1:0]   sel_i,
    output logic [W-1:0]              ins_o,
    output logic [W-1:0]              ext_o
);
    localparam int NB = W / BW;
    localparam int SW = $clog2(NB);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign ins_o[g*BW +: BW] = (sel_i == SW'(g)) ? val_i : word_i[g*BW +: BW];
    end

    always_comb begin
        ext_o = '0;
        for (int b = 0; b < NB; b++) begin
            if (sel_i == SW'(b)) ext_o[BW-1:0] = word_i[b*BW +: BW];
        end
    end

endmodule

// File: rtl/step_alu.sv
module step_alu
    import step_alu_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [OP_W-1:0]                   op_i,
    input  logic [DATA_W-1:0]                 a_i,
    input  logic [DATA_W-1:0]                 b_i,
    input  logic [DATA_W-1:0]                 hi_i,
    input  logic [DATA_W-1:0]                 lo_i,
    input  logic                              bit_i,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]  sel_i,
    output logic [DATA_W-1:0]                 res_o,
    output logic [DATA_W-1:0]                 hi_o,
    output logic [DATA_W-1:0]                 lo_o,
    output logic                              bit_o
);
    localparam int MSB = DATA_W - 1;

    wide_t      add_x, add_y, add_s, booth_mag;
    logic       add_c;
    booth_sel_t bsel;
    word_t      shl_rem, ins_w, ext_w;
    alu_out_t   nxt, q;

    // Operand steering for the single shared adder.
    always_comb begin
        bsel      = booth_recode({lo_i[1:0], bit_i});
        shl_rem   = {hi_i[MSB-1:0], lo_i[MSB]};
        booth_mag = bsel.zero ? '0 :
                    (bsel.dbl ? (sext_word(a_i) << 1) : sext_word(a_i));
        add_x = '0;
        add_y = '0;
        add_c = 1'b0;
        case (op_i)
            OP_ADD: begin
                add_x = sext_word(a_i);
                add_y = sext_word(b_i);
            end
            OP_SUB: begin
                add_x = sext_word(a_i);
                add_y = ~sext_word(b_i);
                add_c = 1'b1;
            end
            OP_MSTEP: begin
                add_x = sext_word(hi_i);
                add_y = bsel.neg ? ~booth_mag : booth_mag;
                add_c = bsel.neg;
            end
            OP_DSTEP: begin
                add_x = sext_word(shl_rem);
                add_y = hi_i[MSB] ? sext_word(a_i) : ~sext_word(a_i);
                add_c = ~hi_i[MSB];
            end
            default: ;
        endcase
    end

    step_alu_cla #(.W(ADD_W), .GS(CLA_GS)) i_cla (
        .x_i (add_x),
        .y_i (add_y),
        .c_i (add_c),
        .s_o (add_s)
    );

    step_alu_bytes #(.W(DATA_W), .BW(BYTE_W)) i_bytes (
        .word_i (a_i),
        .val_i  (b_i[BYTE_W-1:0]),
        .sel_i  (sel_i),
        .ins_o  (ins_w),
        .ext_o  (ext_w)
    );

    // Result and auxiliary-state selection.
    always_comb begin
        nxt = '{res: '0, hi: hi_i, lo: lo_i, bt: bit_i};
        case (op_i)
            OP_ADD, OP_SUB: nxt.res = add_s[MSB:0];
            OP_AND:         nxt.res = a_i & b_i;
            OP_OR:          nxt.res = a_i | b_i;
            OP_XOR:         nxt.res = a_i ^ b_i;
            OP_MSTEP: begin
                nxt.hi  = add_s[DATA_W+1:2];
                nxt.lo  = {add_s[1:0], lo_i[MSB:2]};
                nxt.bt  = lo_i[1];
                nxt.res = add_s[DATA_W+1:2];
            end
            OP_DSTEP: begin
                nxt.hi  = add_s[MSB:0];
                nxt.lo  = {lo_i[MSB-1:0], ~add_s[MSB]};
                nxt.res = add_s[MSB:0];
            end
            OP_BINS:        nxt.res = ins_w;
            OP_BEXT:        nxt.res = ext_w;
            default:        nxt.res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign res_o = q.res;
    assign hi_o  = q.hi;
    assign lo_o  = q.lo;
    assign bit_o = q.bt;

endmodule

// File: rtl/step_alu_chk.sv
module step_alu_chk
    import step_alu_pkg::*;
(
    input logic                              clk,
    input logic                              rst,
    input logic [OP_W-1:0]                   op_i,
    input logic [DATA_W-1:0]                 a_i,
    input logic [DATA_W-1:0]                 b_i,
    input logic [DATA_W-1:0]                 hi_i,
    input logic [DATA_W-1:0]                 lo_i,
    input logic                              bit_i,
    input logic [$clog2(DATA_W/BYTE_W)-1:0]  sel_i,
    input logic [DATA_W-1:0]                 res_o,
    input logic [DATA_W-1:0]                 hi_o,
    input logic [DATA_W-1:0]                 lo_o,
    input logic                              bit_o
);
    logic [$clog2(DATA_W/BYTE_W)-1:0] sel_q;
    always_ff @(posedge clk) sel_q <= sel_i;

    // R10: reset clears every output
    p_rst_clear_r10: assert property (@(posedge clk)
        rst |=> (res_o == '0 && hi_o == '0 && lo_o == '0 && !bit_o));

    // R9: non-step opcodes leave auxiliary state untouched
    p_aux_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !is_step_op(op_i) |=> (hi_o == $past(hi_i) && lo_o == $past(lo_i)
                               && bit_o == $past(bit_i)));

    // R9: spare opcodes yield zero
    p_spare_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_BEXT) |=> (res_o == '0));

    // R8: extract leaves upper bits clear
    p_ext_upper_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BEXT) |=> (res_o[DATA_W-1:BYTE_W] == '0));

    // R7: insert puts operand B's low byte in the chosen lane
    p_ins_lane_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BINS) |=> (res_o[sel_q*BYTE_W +: BYTE_W] == $past(b_i[BYTE_W-1:0])));

    // R3: Booth step shifts the lower word by two and saves lo[1]
    p_mstep_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MSTEP) |=> (bit_o == $past(lo_i[1])
                                && lo_o[DATA_W-3:0] == $past(lo_i[DATA_W-1:2])
                                && res_o == hi_o));

    // R5: divide step quotient bit is the inverted remainder sign
    p_dstep_qbit_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DSTEP) |=> (lo_o[0] == ~hi_o[DATA_W-1]
                                && lo_o[DATA_W-1:1] == $past(lo_i[DATA_W-2:0])
                                && res_o == hi_o));

endmodule

bind step_alu step_alu_chk i_step_alu_chk (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .hi_i  (hi_i),
    .lo_i  (lo_i),
    .bit_i (bit_i),
    .sel_i (sel_i),
    .res_o (res_o),
    .hi_o  (hi_o),
    .lo_o  (lo_o),
    .bit_o (bit_o)
);

// File: tb/test_step_alu.sv
module test_step_alu;
    import step_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op  = '0;
    logic [31:0] a = '0, b = '0, hi = '0, lo = '0;
    logic        bt = 1'b0;
    logic [1:0]  sel = '0;
    logic [31:0] res_o, hi_o, lo_o;
    logic        bit_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    step_alu i_step_alu (
        .clk (clk), .rst (rst), .op_i (op), .a_i (a), .b_i (b),
        .hi_i (hi), .lo_i (lo), .bit_i (bt), .sel_i (sel),
        .res_o (res_o), .hi_o (hi_o), .lo_o (lo_o), .bit_o (bit_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] o, input logic [31:0] ta, tb_, th, tl,
                       input logic tbit, input logic [1:0] ts);
        op = o; a = ta; b = tb_; hi = th; lo = tl; bt = tbit; sel = ts;
        @(posedge clk);
        #1;
    endtask

    task automatic booth_model(input logic [31:0] m, h, l, input logic pb,
                               output logic [31:0] nh, nl, output logic nb);
        int k;
        longint s;
        logic signed [65:0] pair;
        k = int'(l[0]) + int'(pb) - 2 * int'(l[1]);
        s = longint'($signed(h)) + longint'(k) * longint'($signed(m));
        pair = {s[33:0], l};
        pair = pair >>> 2;
        nh = pair[63:32];
        nl = pair[31:0];
        nb = l[1];
    endtask

    task automatic div_model(input logic [31:0] d, h, l,
                             output logic [31:0] nh, nl);
        longint r;
        r = longint'($signed(h)) * 2 + longint'(l[31]);
        if (h[31]) r = r + longint'({32'b0, d});
        else       r = r - longint'({32'b0, d});
        nh = r[31:0];
        nl = {l[30:0], ~r[31]};
    endtask

    task automatic booth_chain(input logic [31:0] x, y);
        logic [31:0] ch = 32'b0, cl = y;
        logic        cb = 1'b0;
        longint      p;
        for (int i = 0; i < 16; i++) begin
            run(4'(OP_MSTEP), x, 32'b0, ch, cl, cb, 2'd0);
            ch = hi_o; cl = lo_o; cb = bit_o;
        end
        p = longint'($signed(x)) * longint'($signed(y));
        chk("R4 product", {ch, cl}, p);
    endtask

    task automatic div_chain(input logic [31:0] n, d);
        logic [31:0] ch = 32'b0, cl = n;
        for (int i = 0; i < 32; i++) begin
            run(4'(OP_DSTEP), d, 32'b0, ch, cl, 1'b0, 2'd0);
            ch = hi_o; cl = lo_o;
        end
        if (ch[31]) ch = ch + d;
        chk("R6 quotient", {32'b0, cl}, {32'b0, n / d});
        chk("R6 remainder", {32'b0, ch}, {32'b0, n % d});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb, rh, rl, eh, el;
        logic        rbit, eb;
        void'($urandom(32'd7741));

        // R10 reset state with busy inputs
        op = 4'(OP_ADD); a = 32'hdead_beef; b = 32'h1234_5678;
        hi = 32'hffff_ffff; lo = 32'h5555_aaaa; bt = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset res", {32'b0, res_o}, 64'd0);
        chk("R10 reset aux", {hi_o, lo_o}, 64'd0);
        chk("R10 reset bit", {63'b0, bit_o}, 64'd0);
        rst = 1'b0;

        // R1 directed carries
        run(4'(OP_ADD), 32'hffff_ffff, 32'd1, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R1 add wrap", {32'b0, res_o}, 64'd0);
        run(4'(OP_SUB), 32'd0, 32'd1, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R1 sub borrow", {32'b0, res_o}, {32'b0, 32'hffff_ffff});
        run(4'(OP_ADD), 32'h7fff_ffff, 32'd1, 32'h0, 32'h0, 1'b0, 2'd0);
        chk("R1 add carry chain", {32'b0, res_o}, {32'b0, 32'h8000_0000});

        // R10 latency: output holds until the next edge
        op = 4'(OP_ADD); a = 32'd5; b = 32'd5;
        #5;
        chk("R10 hold before edge", {32'b0, res_o}, {32'b0, 32'h8000_0000});
        @(posedge clk); #1;
        chk("R10 after edge", {32'b0, res_o}, 64'd10);

        // R1, R2, R9 random
        for (int i = 0; i < 20; i++) begin
            ra = $urandom; rb = $urandom; rh = $urandom; rl = $urandom; rbit = 1'($urandom);
            run(4'(OP_ADD), ra, rb, rh, rl, rbit, 2'd0);
            chk("R1 add", {32'b0, res_o}, {32'b0, ra + rb});
            chk("R9 aux pass", {hi_o, lo_o}, {rh, rl});
            chk("R9 bit pass", {63'b0, bit_o}, {63'b0, rbit});
            run(4'(OP_SUB), ra, rb, rh, rl, rbit, 2'd0);
            chk("R1 sub", {32'b0, res_o}, {32'b0, ra - rb});
            run(4'(OP_AND), ra, rb, rh, rl, rbit, 2'd0);
            chk("R2 and", {32'b0, res_o}, {32'b0, ra & rb});
            run(4'(OP_OR), ra, rb, rh, rl, rbit, 2'd0);
            chk("R2 or", {32'b0, res_o}, {32'b0, ra | rb});
            run(4'(OP_XOR), ra, rb, rh, rl, rbit, 2'd0);
            chk("R2 xor", {32'b0, res_o}, {32'b0, ra ^ rb});
        end

        // R3 every Booth window, then random steps
        for (int w = 0; w < 8; w++) begin
            ra = $urandom; rh = $urandom;
            rl = {$urandom, 2'b00} | 32'(w >> 1);
            rbit = 1'(w);
            run(4'(OP_MSTEP), ra, 32'b0, rh, rl, rbit, 2'd0);
            booth_model(ra, rh, rl, rbit, eh, el, eb);
            chk("R3 booth window hi", {32'b0, hi_o}, {32'b0, eh});
            chk("R3 booth window lo", {32'b0, lo_o}, {32'b0, el});
            chk("R3 booth window bit", {63'b0, bit_o}, {63'b0, eb});
        end
        for (int i = 0; i < 20; i++) begin
            ra = $urandom; rh = $urandom; rl = $urandom; rbit = 1'($urandom);
            run(4'(OP_MSTEP), ra, 32'b0, rh, rl, rbit, 2'd0);
            booth_model(ra, rh, rl, rbit, eh, el, eb);
            chk("R3 booth step", {hi_o, lo_o}, {eh, el});
            chk("R3 booth res", {32'b0, res_o}, {32'b0, eh});
        end

        // R4 chained products
        booth_chain(32'hffff_ffff, 32'hffff_ffff);
        booth_chain(32'h7fff_ffff, 32'h8000_0000);
        booth_chain(32'h8000_0000, 32'h8000_0000);
        booth_chain(32'h0, 32'h1234_5678);
        for (int i = 0; i < 5; i++) booth_chain($urandom, $urandom);

        // R5 random divide steps
        for (int i = 0; i < 20; i++) begin
            ra = $urandom; rh = $urandom; rl = $urandom;
            run(4'(OP_DSTEP), ra, 32'b0, rh, rl, 1'b0, 2'd0);
            div_model(ra, rh, rl, eh, el);
            chk("R5 divide step", {hi_o, lo_o}, {eh, el});
            chk("R5 divide res", {32'b0, res_o}, {32'b0, eh});
        end

        // R6 chained divides
        div_chain(32'd100, 32'd7);
        div_chain(32'hffff_ffff, 32'd1);
        div_chain(32'd0, 32'd5);
        div_chain(32'd12345678, 32'h3fff_ffff);
        div_chain(32'hffff_ffff, 32'h3fff_ffff);
        for (int i = 0; i < 5; i++) div_chain($urandom, ($urandom % 32'h3fff_ffff) + 1);

        // R7 and R8 every byte lane
        for (int s = 0; s < 4; s++) begin
            ra = $urandom; rb = $urandom;
            run(4'(OP_BINS), ra, rb, 32'h0, 32'h0, 1'b0, 2'(s));
            el = ra;
            el[s*8 +: 8] = rb[7:0];
            chk("R7 insert", {32'b0, res_o}, {32'b0, el});
            run(4'(OP_BEXT), ra, rb, 32'h0, 32'h0, 1'b0, 2'(s));
            chk("R8 extract", {32'b0, res_o}, {56'b0, ra[s*8 +: 8]});
        end

        // R9 spare opcodes
        for (int o = 9; o < 16; o++) begin
            ra = $urandom; rh = $urandom; rl = $urandom;
            run(4'(o), ra, ra, rh, rl, 1'b1, 2'd1);
            chk("R9 spare res", {32'b0, res_o}, 64'd0);
            chk("R9 spare aux", {hi_o, lo_o}, {rh, rl});
        end

        // R10 reset in mid-run
        run(4'(OP_OR), 32'hffff_0000, 32'h0000_ffff, 32'h1, 32'h2, 1'b1, 2'd0);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R10 sync reset", {res_o, hi_o}, 64'd0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule